// File: doc/BRIEF.md
# Reference-clock lock and bypass controller

This block watches a slower reference clock from a faster, free-running sampling clock and reports whether that reference can be trusted. Each reference rising edge is brought into the sampling domain and timed against the edge before it. A period no longer than a set maximum counts as a good period. Once a long enough run of good periods has been seen in a row, the block raises its lock flag. If too long a time passes with no good edge, because the reference has stopped or has slowed down, lock falls and the count begins again from zero.

An enable pin held low switches the block into a bypass mode. In bypass, lock is held off and a flag tells the downstream datapath to use its one-cycle-latency path. On its own schedule, the block issues a one-cycle strobe after every fixed number of reference rising edges counted since reset. This strobe asks the output-driver calibration to refresh itself. The time limits are given in picoseconds and converted to sampling-clock counts when the block is elaborated.

Top module: `refclk_lock_ctrl`

## Requirements
- R1: While reset is held low, `locked_o` and `cal_pulse_o` are 0 and `bypass_o` is 1. With `lock_en_i` high, `bypass_o` falls one sampling cycle after reset is released.
- R2: A reference rising edge takes effect on the outputs at the third sampling edge after it appears on the pin. `locked_o` rises on the edge that completes `LOCK_CYCLES` consecutive good periods. The first edge after reset, after a stall or after a slow period opens the run and does not count towards it.
- R3: A period counts as good when it lasts at most `MAX_TICKS` sampling cycles. A longer period seen while lock is being acquired sets the good-period count back to zero. A single such period seen while locked does not drop lock.
- R4: When no good edge arrives for `STALL_TICKS` sampling cycles after the last one, `locked_o` falls and acquisition restarts. Good edges spaced closer than this keep lock.
- R5: A reference that keeps running with periods longer than `MAX_TICKS` drops lock through the R4 timeout, and it cannot acquire lock while it stays slow.
- R6: With `lock_en_i` low, `bypass_o` is 1 and `locked_o` is 0 from the next sampling cycle on, whatever the reference does. After `lock_en_i` returns high, `bypass_o` clears one cycle later and acquisition starts from zero.
- R7: `cal_pulse_o` is high for exactly one sampling cycle on every `CAL_CYCLES`-th reference rising edge since reset, in every mode, so the number of strobes equals the number of rising edges divided by `CAL_CYCLES`, rounded down.
- R8: `STALL_TICKS` is `STALL_PS / SAMPLE_PERIOD_PS` rounded up, and `MAX_TICKS` is `MAX_PERIOD_PS / SAMPLE_PERIOD_PS` rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, faster than twice the reference frequency |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock under watch, asynchronous to `clk_i` |
| lock_en_i | input | 1 | High enables lock tracking; low selects bypass mode |
| locked_o | output | 1 | Reference has been stable long enough to be trusted |
| bypass_o | output | 1 | Bypass mode active: downstream uses the one-cycle-latency path |
| cal_pulse_o | output | 1 | One-cycle request to refresh driver calibration |

## Verification
The bench builds the block with a 4 ns sampling period and the default 30 ns stall and 12.5 ns period limits. This makes the stall limit 8 cycles and the good-period limit 3 cycles, so a 3-cycle reference period is good and a 4-cycle one is slow, and both boundaries can be placed exactly. `LOCK_CYCLES` is cut to 16 and `CAL_CYCLES` to 12. Full acquisitions, repeated stalls and many calibration strobes then fit in a few thousand cycles. Having 12 differ from 16 also keeps a strobe from lining up with a lock event.

// File: rtl/refclk_lock_pkg.sv
// Shared types and elaboration-time helpers for the reference-clock lock controller.
// Assumes all spans are given in picoseconds as positive integers.
package refclk_lock_pkg;

    // Acquisition sequencer states.
    typedef enum logic [1:0] {
        LK_BYPASS  = 2'd0,
        LK_ACQUIRE = 2'd1,
        LK_LOCKED  = 2'd2
    } lock_state_e;

    // Number of whole sampling ticks that cover a span, rounded up.
    function automatic int ticks_ceil(input int span_ps, input int tick_ps);
        return (span_ps + tick_ps - 1) / tick_ps;
    endfunction

    // Number of whole sampling ticks that fit inside a span, rounded down.
    function automatic int ticks_floor(input int span_ps, input int tick_ps);
        return span_ps / tick_ps;
    endfunction

endpackage

// File: rtl/ref_edge_sync.sv
// Brings the asynchronous reference clock into the sampling domain through a
// chain of SYNC_STAGES flops and flags one cycle per reference rising edge.
// Assumes the reference is slower than half the sampling clock.
module ref_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o
);
    // One history flop sits behind the synchronizer stages.
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the reference level through synchronizer and history flops.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ref_i};
        end
    end

    // A rise is a synchronized high whose predecessor was low.
    always_comb begin
        rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end

endmodule

// File: rtl/ref_period_mon.sv
// Times each reference rising edge against the previous one and classifies it.
// good_o: edge ended a period of at most MAX_TICKS cycles.
// slow_o: any other edge, including the first one seen.
// stall_o: one-cycle strobe when STALL_TICKS cycles pass with no good edge.
// Assumes MAX_TICKS >= 1 and STALL_TICKS >= 2.
module ref_period_mon #(
    parameter int MAX_TICKS   = 3,
    parameter int STALL_TICKS = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic good_o,
    output logic slow_o,
    output logic stall_o
);
    localparam int GAP_LIM = MAX_TICKS + 1;
    localparam int GAP_W   = $clog2(GAP_LIM + 1);
    localparam int IDLE_W  = $clog2(STALL_TICKS + 1);

    logic [GAP_W-1:0]  gap_q;
    logic [IDLE_W-1:0] idle_q;
    logic              seen_q;

    // Classify the current edge and detect the end of the stall window.
    always_comb begin
        good_o  = rise_i && seen_q && (gap_q <= GAP_W'(MAX_TICKS));
        slow_o  = rise_i && !good_o;
        stall_o = !good_o && (idle_q == IDLE_W'(STALL_TICKS - 1));
    end

    // Cycles since the last edge of any kind, saturating past the good limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (rise_i) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != GAP_W'(GAP_LIM)) begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    // Cycles since the last good edge, saturating at the stall limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idle_q <= '0;
        end else if (good_o) begin
            idle_q <= IDLE_W'(1);
        end else if (idle_q != IDLE_W'(STALL_TICKS)) begin
            idle_q <= idle_q + IDLE_W'(1);
        end
    end

endmodule

// File: rtl/lock_seq.sv
// Acquisition sequencer: counts consecutive good periods up to LOCK_CYCLES,
// holds lock until a stall, and parks in bypass while the enable is low.
// Assumes LOCK_CYCLES >= 2 and that stall and good never coincide.
module lock_seq
    import refclk_lock_pkg::*;
#(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic good_i,
    input  logic slow_i,
    input  logic stall_i,
    output logic locked_o,
    output logic bypass_o
);
    localparam int RUN_W = $clog2(LOCK_CYCLES);

    lock_state_e      state_q;
    logic [RUN_W-1:0] run_q;

    // Advance the lock state and the good-period run count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= LK_BYPASS;
            run_q   <= '0;
        end else if (!en_i) begin
            state_q <= LK_BYPASS;
            run_q   <= '0;
        end else begin
            unique case (state_q)
                LK_BYPASS: begin
                    state_q <= LK_ACQUIRE;
                    run_q   <= '0;
                end
                LK_ACQUIRE: begin
                    if (stall_i || slow_i) begin
                        run_q <= '0;
                    end else if (good_i) begin
                        if (run_q == RUN_W'(LOCK_CYCLES - 1)) begin
                            state_q <= LK_LOCKED;
                            run_q   <= '0;
                        end else begin
                            run_q <= run_q + RUN_W'(1);
                        end
                    end
                end
                LK_LOCKED: begin
                    if (stall_i) begin
                        state_q <= LK_ACQUIRE;
                        run_q   <= '0;
                    end
                end
                default: begin
                    state_q <= LK_BYPASS;
                    run_q   <= '0;
                end
            endcase
        end
    end

    // Decode status flags from the state.
    always_comb begin
        locked_o = (state_q == LK_LOCKED);
        bypass_o = (state_q == LK_BYPASS);
    end

endmodule

// File: rtl/cal_timer.sv
// Counts reference rising edges and strobes once on every CAL_CYCLES-th edge.
// Runs in every mode from reset on. Assumes CAL_CYCLES >= 2.
module cal_timer #(
    parameter int CAL_CYCLES = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(CAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    // Edge counter with a one-cycle strobe on wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (rise_i) begin
            if (cnt_q == CNT_W'(CAL_CYCLES - 1)) begin
                cnt_q   <= '0;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + CNT_W'(1);
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    // Drive the strobe straight from its flop.
    always_comb begin
        pulse_o = pulse_q;
    end

endmodule

// File: rtl/refclk_lock_ctrl.sv
// Top of the reference-clock lock and bypass controller.
// Converts the picosecond limits to sampling ticks, then chains the edge
// synchronizer, the period monitor, the lock sequencer and the calibration timer.
// Assumes clk_i is free-running and at least twice the reference frequency.
module refclk_lock_ctrl #(
    parameter int LOCK_CYCLES      = 1024,
    parameter int CAL_CYCLES       = 1024,
    parameter int SAMPLE_PERIOD_PS = 2000,
    parameter int STALL_PS         = 30000,
    parameter int MAX_PERIOD_PS    = 12500,
    parameter int SYNC_STAGES      = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_clk_i,
    input  logic lock_en_i,
    output logic locked_o,
    output logic bypass_o,
    output logic cal_pulse_o
);
    localparam int STALL_TICKS = refclk_lock_pkg::ticks_ceil(STALL_PS, SAMPLE_PERIOD_PS);
    localparam int MAX_TICKS   = refclk_lock_pkg::ticks_floor(MAX_PERIOD_PS, SAMPLE_PERIOD_PS);

    logic ref_rise;
    logic good_edge;
    logic slow_edge;
    logic stall_hit;

    ref_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ref_i (ref_clk_i),
        .rise_o(ref_rise)
    );

    ref_period_mon #(
        .MAX_TICKS  (MAX_TICKS),
        .STALL_TICKS(STALL_TICKS)
    ) u_mon (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (ref_rise),
        .good_o (good_edge),
        .slow_o (slow_edge),
        .stall_o(stall_hit)
    );

    lock_seq #(
        .LOCK_CYCLES(LOCK_CYCLES)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (lock_en_i),
        .good_i  (good_edge),
        .slow_i  (slow_edge),
        .stall_i (stall_hit),
        .locked_o(locked_o),
        .bypass_o(bypass_o)
    );

    cal_timer #(
        .CAL_CYCLES(CAL_CYCLES)
    ) u_cal (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (ref_rise),
        .pulse_o(cal_pulse_o)
    );

endmodule

// File: rtl/refclk_lock_checker.sv
// Temporal properties of the lock controller, bound onto every instance of the top.
// Observes ports plus the edge strobe and stall strobe passed between submodules.
module refclk_lock_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic lock_en_i,
    input logic locked_o,
    input logic bypass_o,
    input logic cal_pulse_o,
    input logic ref_rise,
    input logic stall_hit
);
    // R6: a low enable forces bypass and clears lock on the next cycle.
    a_r6_bypass_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_en_i |=> (bypass_o && !locked_o));

    // R6: lock and bypass are never reported together.
    a_r6_no_lock_in_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> !bypass_o);

    // R2: lock can only be gained by a reference edge.
    a_r2_lock_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> $past(ref_rise));

    // R4: the stall strobe always leaves the block unlocked.
    a_r4_stall_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_hit |=> !locked_o);

    // R7: the calibration strobe lasts exactly one cycle.
    a_r7_cal_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_pulse_o |=> !cal_pulse_o);

    // R7: the calibration strobe follows a reference edge.
    a_r7_cal_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cal_pulse_o) |-> $past(ref_rise));

endmodule

bind refclk_lock_ctrl refclk_lock_checker i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_en_i  (lock_en_i),
    .locked_o   (locked_o),
    .bypass_o   (bypass_o),
    .cal_pulse_o(cal_pulse_o),
    .ref_rise   (ref_rise),
    .stall_hit  (stall_hit)
);

// File: tb/test_refclk_lock_ctrl.sv
`timescale 1ns/1ps
module test_refclk_lock_ctrl;
    localparam int LOCK_N  = 16;
    localparam int CAL_N   = 12;
    localparam int TICK_PS = 4000;
    // R8: 30 ns over 4 ns rounded up, 12.5 ns over 4 ns rounded down.
    localparam int STALL_T = 8;
    localparam int MAX_T   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic lock_en = 1'b1;
    logic locked, bypass, cal_pulse;

    int errors = 0;
    int checks = 0;
    int rise_cnt = 0;
    int cal_seen = 0;

    // Bench model of the requirements.
    int run_m = 0;
    int exp_lock = 0;
    int pend_gap = 1000;
    int since_good = 1000;
    bit has_prev = 1'b0;
    bit has_good = 1'b0;
    bit en_model = 1'b1;

    refclk_lock_ctrl #(
        .LOCK_CYCLES     (LOCK_N),
        .CAL_CYCLES      (CAL_N),
        .SAMPLE_PERIOD_PS(TICK_PS),
        .STALL_PS        (30000),
        .MAX_PERIOD_PS   (12500),
        .SYNC_STAGES     (2)
    ) i_refclk_lock_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ref_clk_i  (ref_clk),
        .lock_en_i  (lock_en),
        .locked_o   (locked),
        .bypass_o   (bypass),
        .cal_pulse_o(cal_pulse)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && cal_pulse) cal_seen++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        pend_gap++;
        since_good++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic int cal_expect(input int rises);
        return rises / CAL_N;
    endfunction

    // One reference rise, followed by p sampling cycles before the next one.
    task automatic pulse(input int p, input bit do_chk, input string tag);
        bit good_en, good_phys;
        int expv, hi;
        if (do_chk && pend_gap >= 3) begin
            if (!(has_good && since_good >= STALL_T && since_good < STALL_T + 2)) begin
                expv = (has_good && since_good >= STALL_T + 2) ? 0 : exp_lock;
                chk(locked == expv, tag, int'(locked), expv);
            end
        end
        if (has_good && since_good >= STALL_T) begin
            exp_lock = 0;
            run_m = 0;
        end
        good_phys = has_prev && (pend_gap <= MAX_T);
        good_en = good_phys && en_model;
        if (!en_model) begin
            exp_lock = 0;
            run_m = 0;
        end else if (!good_en) begin
            if (exp_lock == 0) run_m = 0;
        end else if (exp_lock == 0) begin
            run_m++;
            if (run_m == LOCK_N) begin
                exp_lock = 1;
                run_m = 0;
            end
        end
        if (good_phys) begin
            since_good = 0;
            has_good = 1'b1;
        end
        has_prev = 1'b1;
        pend_gap = 0;
        ref_clk = 1'b1;
        rise_cnt++;
        hi = p / 2;
        for (int i = 0; i < p; i++) begin
            if (i == hi) ref_clk = 1'b0;
            tick();
        end
    endtask

    task automatic set_en(input bit v);
        lock_en = v;
        en_model = v;
        if (!v) begin
            exp_lock = 0;
            run_m = 0;
        end
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        int p, prev_p;
        seed_init = $urandom(32'd7301);

        // R1: reset values.
        idle(5);
        chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        chk(bypass == 1'b1, "R1 bypass in reset", int'(bypass), 1);
        chk(cal_pulse == 1'b0, "R1 cal in reset", int'(cal_pulse), 0);
        rst_n = 1'b1;
        tick();
        chk(bypass == 1'b0, "R1 bypass after release", int'(bypass), 0);
        idle(4);

        // R2: acquisition with 3-cycle periods, lock exactly on edge LOCK_N+1.
        for (int i = 0; i < LOCK_N; i++) pulse(3, 1'b1, "R2 acquire");
        chk(locked == 1'b0, "R2 one good period short", int'(locked), 0);
        pulse(3, 1'b1, "R2 acquire");
        chk(locked == 1'b1, "R2 lock after full run", int'(locked), 1);
        for (int i = 0; i < 3; i++) pulse(3, 1'b1, "R2 hold");

        // R4, R8: exact stall window after the last good edge.
        idle(STALL_T - 2);
        chk(locked == 1'b1, "R4 still locked inside stall window", int'(locked), 1);
        idle(1);
        chk(locked == 1'b0, "R8 lock dropped at stall limit", int'(locked), 0);
        idle(6);
        chk(cal_seen == cal_expect(rise_cnt), "R7 strobe count", cal_seen, cal_expect(rise_cnt));

        // R3: a 4-cycle period during acquisition restarts the count.
        for (int i = 0; i < LOCK_N - 2; i++) pulse(3, 1'b1, "R3 acquire");
        pulse(4, 1'b1, "R3 acquire");
        for (int i = 0; i < LOCK_N; i++) pulse(3, 1'b1, "R3 restart");
        chk(locked == 1'b0, "R3 slow period reset the run", int'(locked), 0);
        pulse(3, 1'b1, "R3 restart");
        chk(locked == 1'b1, "R3 lock after restarted run", int'(locked), 1);

        // R3, R4: one slow period while locked keeps lock.
        pulse(4, 1'b1, "R4 single slow");
        pulse(3, 1'b1, "R4 single slow");
        pulse(3, 1'b1, "R4 single slow");
        chk(locked == 1'b1, "R4 short gap keeps lock", int'(locked), 1);

        // R5: a continuously slow reference loses lock and cannot regain it.
        for (int i = 0; i < 6; i++) pulse(4, 1'b1, "R5 slow run");
        chk(locked == 1'b0, "R5 slow reference drops lock", int'(locked), 0);
        for (int i = 0; i < LOCK_N + 2; i++) pulse(4, 1'b1, "R5 slow run");
        chk(locked == 1'b0, "R5 no lock while slow", int'(locked), 0);

        // R6: bypass while disabled, then acquisition restarts from zero.
        idle(10);
        set_en(1'b0);
        chk(bypass == 1'b1, "R6 bypass on disable", int'(bypass), 1);
        for (int i = 0; i < LOCK_N + 3; i++) pulse(3, 1'b1, "R6 disabled");
        chk(locked == 1'b0, "R6 no lock in bypass", int'(locked), 0);
        chk(bypass == 1'b1, "R6 bypass held", int'(bypass), 1);
        idle(10);
        set_en(1'b1);
        chk(bypass == 1'b0, "R6 bypass cleared", int'(bypass), 0);
        idle(4);
        for (int i = 0; i < LOCK_N; i++) pulse(3, 1'b1, "R6 reacquire");
        chk(locked == 1'b0, "R6 restart from zero", int'(locked), 0);
        pulse(3, 1'b1, "R6 reacquire");
        chk(locked == 1'b1, "R6 relock", int'(locked), 1);
        idle(12);
        chk(cal_seen == cal_expect(rise_cnt), "R7 strobe count", cal_seen, cal_expect(rise_cnt));

        // R2: fastest reference, 2-cycle periods.
        for (int i = 0; i < LOCK_N + 1; i++) pulse(2, 1'b1, "R2 fast");
        idle(3);
        chk(locked == 1'b1, "R2 lock with 2-cycle periods", int'(locked), 1);
        idle(12);

        // R2, R3, R4: random mix of good, slow and stalled references.
        prev_p = 3;
        for (int i = 0; i < 400; i++) begin
            if (prev_p == 4) p = 3;
            else p = (($urandom() % 8) == 0) ? 4 : 3;
            pulse(p, 1'b1, "R4 random stream");
            prev_p = p;
            if (($urandom() % 64) == 0) begin
                idle(6 + int'($urandom() % 6));
                prev_p = 4;
            end
        end
        idle(12);
        chk(locked == 1'b0, "R4 stopped reference unlocked", int'(locked), 0);
        chk(cal_seen == cal_expect(rise_cnt), "R7 final strobe count", cal_seen, cal_expect(rise_cnt));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule